// File: doc/BRIEF.md
# Multi-Channel DMA Trigger Controller

This block is the request front end of a four-channel DMA engine. Each channel has a 4-bit source code that picks what starts it: a software trigger, the rising or falling edge of the channel's own external request pin, or one of twelve peripheral event strobes. When the chosen event fires, the channel's pending flag is latched. The flag stays set until that channel is granted a transfer start, so one trigger can wait while the channel is disabled or the engine is busy.

A small register port gives software four byte-wide locations. Two of them hold the source codes, two channels per byte. One fires software triggers. One reads the pending flags and clears them on a write of 1. A fixed-priority arbiter issues at most one start per cycle, and only while the engine is idle. The engine stays busy until it returns a done strobe. Two more requesters from a second DMA class, a software request and a hardware request, rank below the four channels. The events that reach this block may also drive interrupt cause flags elsewhere. This block never touches those flags, and no interrupt setting gates a trigger.

Top module: `dma_trig_ctrl`

## Requirements
- R1: After reset all pending flags are 0, both source-code bytes read 0xFF (code 15 on every channel), the trigger location reads 0x00, `gnt` is 0 and `busy` is 0.
- R2: Address 0 holds the code of channel 0 in bits 3:0 and of channel 1 in bits 7:4. Address 1 does the same for channels 2 and 3. A written value reads back unchanged in the cycle after the write.
- R3: A write to address 2 with bit c set makes channel c pending at the next clock edge, but only if the code of channel c is 0. Otherwise the write has no effect.
- R4: Code 1 makes channel c pending on a falling edge of `req_pin[c]`, and code 2 on a rising edge. Because of a two-flop synchronizer, the flag is set at the third clock edge after the pin changes and not earlier.
- R5: Codes 3 to 14 select `periph_evt[c*12 + code-3]`. A strobe that is high at a clock edge sets the flag of channel c at that edge.
- R6: Code 15 never triggers. Some codes are reserved and also never trigger: code 5 on every channel, code 8 on channels 2 and 3, and code 10 on channel 3.
- R7: Address 3 reads the pending flags in bits 3:0, with bit c for channel c. A flag stays set for as long as it is neither granted nor cleared.
- R8: When the engine is idle, `gnt` is asserted in the same cycle as a channel that is enabled and pending. At the next edge that flag clears and `busy` rises. `busy` then holds until the edge at which `eng_done` is high.
- R9: A write to address 3 clears each flag whose data bit is 1. A 0 bit leaves its flag unchanged.
- R10: `gnt` is one-hot or zero, with bits 0 to 3 for channels 0 to 3, bit 4 for `idma_sw_req` and bit 5 for `idma_hw_req`. The lowest pending index wins.
- R11: If a trigger arrives in the same cycle as a software clear or a transfer start for that channel, the flag is still set after the edge.
- R12: A pending channel whose `chan_en` bit is 0 receives no grant and keeps its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0,1 codes; 2 trigger; 3 flags) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| req_pin | input | 4 | Asynchronous external request pins, one per channel |
| periph_evt | input | 48 | Peripheral event strobes, 12 per channel |
| chan_en | input | 4 | Channel enables |
| idma_sw_req | input | 1 | Second-class software request (level) |
| idma_hw_req | input | 1 | Second-class hardware request (level) |
| eng_done | input | 1 | Engine finished the current transfer |
| gnt | output | 6 | One-hot start grant |
| busy | output | 1 | Engine busy with a granted transfer |

## Verification
Reads are combinational, so each one is sampled a time unit after the address is set. A write, a software trigger, a clear or a peripheral strobe takes effect at the single edge after it is driven, so the bench drives at the falling edge and samples at the next falling edge. A pin change needs three edges. The bench samples the flag after two edges and expects 0, then after three edges and expects the selected edge's result. A grant is combinational and is checked in the same cycle its conditions hold. The flag clear and `busy` are checked one edge later, and the release of `busy` one edge after `eng_done`.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int SEL_W = 4;
  localparam int NCODE = 16;
  localparam int NEVT  = 12;

  typedef enum logic [SEL_W-1:0] {
    SRC_SW        = 4'd0,
    SRC_PIN_FALL  = 4'd1,
    SRC_PIN_RISE  = 4'd2,
    SRC_EVT_FIRST = 4'd3,
    SRC_EVT_LAST  = 4'd14,
    SRC_OFF       = 4'd15
  } src_code_e;

  // A code may trigger only if it is not the idle code and not reserved.
  function automatic logic code_usable(input logic [NCODE-1:0] rsvd,
                                       input logic [SEL_W-1:0] code);
    return (code != SRC_OFF) && !rsvd[code];
  endfunction

  // Peripheral strobe index selected by an event code.
  function automatic logic [SEL_W-1:0] evt_index(input logic [SEL_W-1:0] code);
    return code - SRC_EVT_FIRST;
  endfunction
endpackage

// File: rtl/dtc_edge_sync.sv
module dtc_edge_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;
endmodule

// File: rtl/dtc_src_sel.sv
module dtc_src_sel import dtc_pkg::*; #(
  parameter logic [NCODE-1:0] RSVD = '0
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             sw_hit,
  input  logic             pin_rise,
  input  logic             pin_fall,
  input  logic [NEVT-1:0]  evt,
  output logic             trig
);
  logic raw;

  always_comb begin
    raw = 1'b0;
    if (sel == SRC_SW)
      raw = sw_hit;
    else if (sel == SRC_PIN_FALL)
      raw = pin_fall;
    else if (sel == SRC_PIN_RISE)
      raw = pin_rise;
    else if (sel >= SRC_EVT_FIRST && sel <= SRC_EVT_LAST)
      raw = evt[evt_index(sel)];
    trig = raw && code_usable(RSVD, sel);
  end
endmodule

// File: rtl/dtc_arb.sv
module dtc_arb #(
  parameter int N = 6
) (
  input  logic         en,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (en && req[i]) gnt = N'(1) << i;
    end
  end
endmodule

// File: rtl/dma_trig_ctrl.sv
module dma_trig_ctrl import dtc_pkg::*; #(
  parameter int NCH = 4,
  parameter logic [NCH*NCODE-1:0] RSVD_MASK = 64'h0520_0120_0020_0020
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [1:0]              reg_addr,
  input  logic [7:0]              reg_wdata,
  output logic [7:0]              reg_rdata,
  input  logic [NCH-1:0]          req_pin,
  input  logic [NCH*NEVT-1:0]     periph_evt,
  input  logic [NCH-1:0]          chan_en,
  input  logic                    idma_sw_req,
  input  logic                    idma_hw_req,
  input  logic                    eng_done,
  output logic [NCH+1:0]          gnt,
  output logic                    busy
);
  localparam int NSELREG  = NCH / 2;
  localparam int NREQ     = NCH + 2;
  localparam int AW       = 2;
  localparam int SWT_ADDR = NSELREG;
  localparam int FLG_ADDR = NSELREG + 1;

  logic [NCH-1:0][SEL_W-1:0] sel_q;
  logic [NCH*SEL_W-1:0]      sel_flat;
  logic [NCH-1:0]            sw_hit, flag_clr, pin_rise, pin_fall, trig, start, flag;
  logic [NREQ-1:0]           req;
  logic                      busy_q;

  assign sel_flat = sel_q;

  // Source-code registers, two channels per byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= {NCH{4'hF}};
    end else if (reg_wr) begin
      for (int r = 0; r < NSELREG; r++) begin
        if (reg_addr == AW'(r)) begin
          sel_q[2*r]   <= reg_wdata[3:0];
          sel_q[2*r+1] <= reg_wdata[7:4];
        end
      end
    end
  end

  assign sw_hit   = (reg_wr && reg_addr == AW'(SWT_ADDR)) ? reg_wdata[NCH-1:0] : '0;
  assign flag_clr = (reg_wr && reg_addr == AW'(FLG_ADDR)) ? reg_wdata[NCH-1:0] : '0;

  dtc_edge_sync #(.W(NCH)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (req_pin),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dtc_src_sel #(.RSVD(RSVD_MASK[c*NCODE +: NCODE])) u_src (
      .sel     (sel_q[c]),
      .sw_hit  (sw_hit[c]),
      .pin_rise(pin_rise[c]),
      .pin_fall(pin_fall[c]),
      .evt     (periph_evt[c*NEVT +: NEVT]),
      .trig    (trig[c])
    );
  end

  // Pending flags: a new trigger wins over a clear or a start in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= '0;
    else        flag <= (flag & ~(start | flag_clr)) | trig;
  end

  assign req = {idma_hw_req, idma_sw_req, flag & chan_en};

  dtc_arb #(.N(NREQ)) u_arb (
    .en (!busy_q),
    .req(req),
    .gnt(gnt)
  );

  assign start = gnt[NCH-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_q <= 1'b0;
    else if (|gnt)     busy_q <= 1'b1;
    else if (eng_done) busy_q <= 1'b0;
  end

  assign busy = busy_q;

  always_comb begin
    reg_rdata = '0;
    for (int r = 0; r < NSELREG; r++) begin
      if (reg_addr == AW'(r)) reg_rdata = {sel_q[2*r+1], sel_q[2*r]};
    end
    if (reg_addr == AW'(FLG_ADDR)) reg_rdata[NCH-1:0] = flag;
  end
endmodule

// File: rtl/dtc_chk.sv
module dtc_chk import dtc_pkg::*; #(
  parameter int NCH = 4,
  parameter logic [NCH*NCODE-1:0] RSVD_MASK = '0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NCH+1:0]       gnt,
  input logic                 busy,
  input logic                 eng_done,
  input logic [NCH-1:0]       flag,
  input logic [NCH-1:0]       trig,
  input logic [NCH-1:0]       chan_en,
  input logic [NCH*SEL_W-1:0] sel_flat
);
  // R10
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));

  // R8
  gnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (gnt == '0));

  // R8
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n) (gnt != '0) |=> busy);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_done) |=> busy);

  // R11
  trig_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig != '0) |=> ((flag & $past(trig)) == $past(trig)));

  // R8
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt[NCH-1:0] & ~trig) != '0) |=> ((flag & $past(gnt[NCH-1:0] & ~trig)) == '0));

  // R12
  gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt[NCH-1:0] & ~(flag & chan_en)) == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_rsvd
    // R6
    no_rsvd_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig[c] |-> (sel_flat[c*SEL_W +: SEL_W] != 4'hF &&
                   !RSVD_MASK[c*NCODE + int'(sel_flat[c*SEL_W +: SEL_W])]));
  end
endmodule

bind dma_trig_ctrl dtc_chk #(.NCH(NCH), .RSVD_MASK(RSVD_MASK)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .gnt     (gnt),
  .busy    (busy),
  .eng_done(eng_done),
  .flag    (flag),
  .trig    (trig),
  .chan_en (chan_en),
  .sel_flat(sel_flat)
);

// File: tb/sim_dma_trig_ctrl.sv
module sim_dma_trig_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [3:0]  req_pin = '0;
  logic [47:0] periph_evt = '0;
  logic [3:0]  chan_en = '0;
  logic        idma_sw_req = 1'b0;
  logic        idma_hw_req = 1'b0;
  logic        eng_done = 1'b0;
  logic [5:0]  gnt;
  logic        busy;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  dma_trig_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_pin(req_pin),
    .periph_evt(periph_evt), .chan_en(chan_en), .idma_sw_req(idma_sw_req),
    .idma_hw_req(idma_hw_req), .eng_done(eng_done), .gnt(gnt), .busy(busy)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    reg_addr = 2'(a);
    #1;
    v = int'(reg_rdata);
  endtask

  function automatic bit is_rsvd(input int ch, input int code);
    return code == 15 || code == 5 || (ch >= 2 && code == 8) || (ch == 3 && code == 10);
  endfunction

  function automatic int code_byte(input int ch, input int code);
    return (ch % 2 == 0) ? (8'hF0 | code) : ((code << 4) | 8'h0F);
  endfunction

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    int pats[4] = '{8'h00, 8'h5A, 8'hA5, 8'h3C};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, v); chk("R1 code byte 0", v, 8'hFF);
    rd(1, v); chk("R1 code byte 1", v, 8'hFF);
    rd(2, v); chk("R1 trigger location", v, 0);
    rd(3, v); chk("R1 flags", v, 0);
    chk("R1 gnt", int'(gnt), 0);
    chk("R1 busy", int'(busy), 0);

    // R2 code registers read back
    for (int a = 0; a < 2; a++) begin
      for (int p = 0; p < 4; p++) begin
        wr(a, pats[p]);
        rd(a, v); chk("R2 readback", v, pats[p]);
      end
    end
    wr(0, 8'hFF); wr(1, 8'hFF);
    rd(3, v); chk("R2 no side trigger", v, 0);

    // Sweep every channel and code over every source kind
    for (int ch = 0; ch < 4; ch++) begin
      for (int code = 0; code < 16; code++) begin
        bit ok;
        ok = !is_rsvd(ch, code);
        wr(ch / 2, code_byte(ch, code));
        // R3 software trigger, all bits written
        wr(2, 8'h0F);
        rd(3, v); chk("R3 software trigger", v, (code == 0) ? (1 << ch) : 0);
        wr(3, 8'h0F);
        // R5 R6 peripheral strobes
        for (int e = 0; e < 12; e++) begin
          periph_evt[ch*12 + e] = 1'b1;
          step();
          periph_evt[ch*12 + e] = 1'b0;
          rd(3, v);
          chk(ok ? "R5 peripheral event" : "R6 reserved code", v,
              (ok && code == e + 3) ? (1 << ch) : 0);
          if (v != 0) wr(3, 8'h0F);
        end
        // R4 pin rising then falling
        req_pin[ch] = 1'b1;
        step(); step();
        rd(3, v); chk("R4 rise too early", v, 0);
        step();
        rd(3, v); chk("R4 rising edge", v, (code == 2) ? (1 << ch) : 0);
        wr(3, 8'h0F);
        req_pin[ch] = 1'b0;
        step(); step();
        rd(3, v); chk("R4 fall too early", v, 0);
        step();
        rd(3, v); chk("R4 falling edge", v, (code == 1) ? (1 << ch) : 0);
        wr(3, 8'h0F);
      end
      wr(ch / 2, 8'hFF);
    end

    // R7 R12 pending but disabled
    wr(0, 8'h00); wr(1, 8'h00);
    wr(2, 8'h0F);
    rd(3, v); chk("R3 all pending", v, 8'h0F);
    step(); step(); step();
    chk("R12 no grant while disabled", int'(gnt), 0);
    rd(3, v); chk("R7 R12 flags held", v, 8'h0F);

    // R8 R10 priority order
    chan_en = 4'hF; idma_sw_req = 1'b1; idma_hw_req = 1'b1;
    for (int i = 0; i < 6; i++) begin
      #1;
      chk("R10 grant order", int'(gnt), 1 << i);
      step();
      chk("R8 busy after start", int'(busy), 1);
      chk("R8 no grant while busy", int'(gnt), 0);
      rd(3, v); chk("R8 flag cleared by start", v, (i < 4) ? (8'h0F & ~((2 << i) - 1)) : 0);
      if (i == 4) idma_sw_req = 1'b0;
      if (i == 5) idma_hw_req = 1'b0;
      step();
      chk("R8 busy held until done", int'(busy), 1);
      eng_done = 1'b1;
      step();
      eng_done = 1'b0;
      chk("R8 busy released", int'(busy), 0);
    end
    #1; chk("R10 nothing left", int'(gnt), 0);
    chan_en = '0;

    // R9 software clear
    wr(2, 8'h0F);
    wr(3, 8'h05);
    rd(3, v); chk("R9 clear selected bits", v, 8'h0A);
    wr(3, 8'h00);
    rd(3, v); chk("R9 zero bits ignored", v, 8'h0A);
    wr(3, 8'h0A);
    rd(3, v); chk("R9 clear rest", v, 0);

    // R11 trigger coinciding with clear and with start
    wr(0, 8'h03);
    periph_evt[0] = 1'b1; step(); periph_evt[0] = 1'b0;
    rd(3, v); chk("R5 channel 0 pending", v, 1);
    reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h01; periph_evt[0] = 1'b1;
    step();
    reg_wr = 1'b0; periph_evt[0] = 1'b0;
    rd(3, v); chk("R11 trigger beats clear", v, 1);
    chan_en = 4'h1; periph_evt[0] = 1'b1;
    #1; chk("R8 grant same cycle", int'(gnt), 1);
    step();
    periph_evt[0] = 1'b0; chan_en = '0;
    chk("R8 busy after start", int'(busy), 1);
    rd(3, v); chk("R11 trigger beats start", v, 1);
    eng_done = 1'b1; step(); eng_done = 1'b0;
    chk("R8 busy released", int'(busy), 0);
    chk("R12 disabled no grant", int'(gnt), 0);
    rd(3, v); chk("R12 flag kept", v, 1);
    wr(3, 8'h0F);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule